// File: doc/BRIEF.md
# Global-History Selected Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a two-bit record of the outcomes of the two most recently resolved branches. That record picks one of four pattern tables. Each table is indexed by bits of the branch address and holds one two-bit saturating counter per entry. As a result, the same branch address can learn a different behaviour for each combination of the two outcomes before it. This lets the block capture branches whose direction depends on their neighbours.

The fetch side gives the block a PC. In the same cycle, with no register on the path, the block returns a taken / not-taken prediction and the history value used to form it. The pipeline carries that history value along with the branch. When the branch resolves, the execute side presents the branch PC, the carried history value and the real outcome. The block then trains the counter in the table that the carried value names, and shifts the outcome into the history register. Because of this, training always lands on the entry that made the prediction, even when newer branches have moved the history register in the meantime. Branch targets and address tags are not part of this block.

Top module: `gh_branch_predictor`

## Requirements
- R1: After reset, the history register is 0 and every counter in all four tables holds 01, so every lookup predicts not taken.
- R2: `lu_hist` is the current history register value. `lu_taken` is the upper bit of the counter selected by `lu_hist` and by index `lu_pc[11:2]`. Both are combinational from the lookup PC and the state.
- R3: The table number equals the history value. Bit 1 is the most recent outcome and bit 0 is the one before it (1 = taken). Value 0 means both were not taken. Value 1 means the older was taken and the newer not. Value 2 means the older was not taken and the newer was. Value 3 means both were taken.
- R4: On a clock edge with `upd_valid` high, the history becomes {`upd_taken`, old bit 1}.
- R5: While `upd_valid` is low, neither the history nor any counter changes, whatever the other update inputs carry.
- R6: An update adds 1 to the addressed counter when taken and subtracts 1 when not taken, saturating at 11 and 00. A counter predicts taken when it is 10 or 11.
- R7: An update trains only the entry at index `upd_pc[11:2]` in the table numbered `upd_hist`, whatever the current history is. Entries in the other tables are left unchanged.
- R8: When a lookup reads the same entry that an update writes in the same cycle, the lookup returns the value from before the update.
- R9: PC bits outside [11:2] take no part in indexing. Addresses that differ only there share an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lu_pc | input | 32 | PC of the branch being fetched |
| lu_taken | output | 1 | Predicted direction, 1 = taken |
| lu_hist | output | 2 | History value used for this prediction |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_hist | input | 2 | History value carried from that branch's lookup |
| upd_taken | input | 1 | Real outcome, 1 = taken |

## Verification
The hardest thing to observe is a counter in a table other than the one the current history selects. A lookup can only read the table that the live history names, and every resolve that could steer the history also trains some entry. The bench therefore steers the history with two resolves to a scratch address whose index is never examined. Two outcomes set the history to any chosen value, so the bench can reach each table in turn. This makes it possible to show that training under one carried history leaves the other three tables untouched, and that a counter needs two opposing updates before its prediction flips.

// File: rtl/gh_bp_pkg.sv
package gh_bp_pkg;

   // Number of pattern tables addressed by a history of the given width.
   function automatic int unsigned tbl_count(input int unsigned hist_w);
      return 32'd1 << hist_w;
   endfunction

   // Mask of the PC bits that form the table index.
   function automatic logic [63:0] idx_mask(input int unsigned lsb, input int unsigned w);
      logic [63:0] m;
      m = '0;
      for (int unsigned i = 0; i < 64; i++) begin
         if (i >= lsb && i < lsb + w) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/gh_hist_reg.sv
module gh_hist_reg #(
   parameter int HIST_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [HIST_W-1:0] hist_o
);
   logic [HIST_W-1:0] q;

   // Newest outcome enters at the top; older outcomes move toward bit 0.
   always_ff @(posedge clk) begin
      if (rst)           q <= '0;
      else if (shift_en) q <= {bit_in, q[HIST_W-1:1]};
   end

   assign hist_o = q;
endmodule

// File: rtl/gh_pattern_table.sv
module gh_pattern_table #(
   parameter int IDX_W = 10,
   parameter int CTR_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CTR_W-1:0] rd_ctr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken
);
   localparam int DEPTH = 1 << IDX_W;
   localparam logic [CTR_W-1:0] CTR_ONE  = {{(CTR_W-1){1'b0}}, 1'b1};
   localparam logic [CTR_W-1:0] CTR_MAX  = '1;
   localparam logic [CTR_W-1:0] CTR_MIN  = '0;
   // Weakly not taken: one step below the taken threshold.
   localparam logic [CTR_W-1:0] CTR_INIT = {1'b0, {(CTR_W-1){1'b1}}};

   logic [CTR_W-1:0] mem [DEPTH];
   logic [CTR_W-1:0] cur;
   logic [CTR_W-1:0] nxt;

   assign cur = mem[wr_idx];

   always_comb begin
      nxt = cur;
      if (wr_taken) begin
         if (cur != CTR_MAX) nxt = cur + CTR_ONE;
      end else begin
         if (cur != CTR_MIN) nxt = cur - CTR_ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
      end else if (wr_en) begin
         mem[wr_idx] <= nxt;
      end
   end

   // Read sees the stored value, so a same-cycle write is not forwarded.
   assign rd_ctr = mem[rd_idx];
endmodule

// File: rtl/gh_branch_predictor.sv
module gh_branch_predictor #(
   parameter int PC_W    = 32,
   parameter int IDX_LSB = 2,
   parameter int IDX_W   = 10,
   parameter int HIST_W  = 2,
   parameter int CTR_W   = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PC_W-1:0]   lu_pc,
   output logic              lu_taken,
   output logic [HIST_W-1:0] lu_hist,
   input  logic              upd_valid,
   input  logic [PC_W-1:0]   upd_pc,
   input  logic [HIST_W-1:0] upd_hist,
   input  logic              upd_taken
);
   import gh_bp_pkg::*;

   localparam int N_TBL = int'(tbl_count(HIST_W));
   localparam logic [PC_W-1:0] IDX_MASK = PC_W'(idx_mask(IDX_LSB, IDX_W));

   generate
      if (HIST_W < 2 || HIST_W > 4) begin : g_bad_hist
         $error("HIST_W must be 2 to 4");
      end
      if (CTR_W < 2 || CTR_W > 8) begin : g_bad_ctr
         $error("CTR_W must be 2 to 8");
      end
      if (IDX_LSB + IDX_W > PC_W) begin : g_bad_idx
         $error("index field exceeds PC width");
      end
   endgenerate

   logic [IDX_W-1:0]  lu_idx;
   logic [IDX_W-1:0]  upd_idx;
   logic [HIST_W-1:0] hist_q;
   logic [CTR_W-1:0]  rd_ctr [N_TBL];
   logic              unused_pc_bits;

   assign lu_idx  = lu_pc[IDX_LSB +: IDX_W];
   assign upd_idx = upd_pc[IDX_LSB +: IDX_W];
   assign unused_pc_bits = ^{lu_pc & ~IDX_MASK, upd_pc & ~IDX_MASK};

   gh_hist_reg #(.HIST_W(HIST_W)) u_hist (
      .clk      (clk),
      .rst      (rst),
      .shift_en (upd_valid),
      .bit_in   (upd_taken),
      .hist_o   (hist_q)
   );

   generate
      for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
         logic wr_sel;
         assign wr_sel = upd_valid && (upd_hist == HIST_W'(t));
         gh_pattern_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_tbl (
            .clk      (clk),
            .rst      (rst),
            .rd_idx   (lu_idx),
            .rd_ctr   (rd_ctr[t]),
            .wr_en    (wr_sel),
            .wr_idx   (upd_idx),
            .wr_taken (upd_taken)
         );
      end
   endgenerate

   logic [CTR_W-1:0] sel_ctr;
   assign sel_ctr  = rd_ctr[hist_q];
   assign lu_taken = sel_ctr[CTR_W-1];
   assign lu_hist  = hist_q;
endmodule

// File: rtl/gh_bp_checker.sv
module gh_bp_checker #(
   parameter int PC_W    = 32,
   parameter int IDX_LSB = 2,
   parameter int IDX_W   = 10,
   parameter int HIST_W  = 2
) (
   input logic              clk,
   input logic              rst,
   input logic [PC_W-1:0]   lu_pc,
   input logic              lu_taken,
   input logic [HIST_W-1:0] lu_hist,
   input logic              upd_valid,
   input logic [PC_W-1:0]   upd_pc,
   input logic [HIST_W-1:0] upd_hist,
   input logic              upd_taken
);
   logic same_entry;
   assign same_entry = (lu_pc[IDX_LSB +: IDX_W] == upd_pc[IDX_LSB +: IDX_W])
                       && (lu_hist == upd_hist);

   // R1: history is clear on the first cycle out of reset
   p_hist_reset_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (lu_hist == '0));

   // R4: a valid update shifts its outcome into the top bit
   p_hist_shift_r4: assert property (@(posedge clk) disable iff (rst)
      upd_valid |=> (lu_hist == {$past(upd_taken), $past(lu_hist[HIST_W-1:1])}));

   // R5: without an update the history holds
   p_hist_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !upd_valid |=> $stable(lu_hist));

   // R6: a taken update never turns a taken prediction of the same entry off
   p_taken_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      (upd_valid && upd_taken && same_entry && lu_taken) |=>
      (!($stable(lu_pc) && lu_hist == $past(lu_hist)) || lu_taken));

   // R6: a not-taken update never turns a not-taken prediction on
   p_ntaken_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      (upd_valid && !upd_taken && same_entry && !lu_taken) |=>
      (!($stable(lu_pc) && lu_hist == $past(lu_hist)) || !lu_taken));
endmodule

bind gh_branch_predictor gh_bp_checker #(
   .PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W)
) u_chk (
   .clk(clk), .rst(rst), .lu_pc(lu_pc), .lu_taken(lu_taken), .lu_hist(lu_hist),
   .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_hist(upd_hist), .upd_taken(upd_taken)
);

// File: tb/gh_branch_predictor_test.sv
module gh_branch_predictor_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] SCRATCH = 32'h0000_0FFC;

   logic        clk = 1'b0;
   logic        rst;
   logic [31:0] lu_pc;
   logic        lu_taken;
   logic [1:0]  lu_hist;
   logic        upd_valid;
   logic [31:0] upd_pc;
   logic [1:0]  upd_hist;
   logic        upd_taken;

   always #(CLK_PERIOD/2) clk = ~clk;

   gh_branch_predictor uut (
      .clk(clk), .rst(rst), .lu_pc(lu_pc), .lu_taken(lu_taken), .lu_hist(lu_hist),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_hist(upd_hist), .upd_taken(upd_taken)
   );

   int n_run = 0;
   int n_fail = 0;
   logic done = 1'b0;
   logic [1:0] mdl [4][1024];
   logic [1:0] mh;

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Update model and design together; returns 1 ns after the edge.
   task automatic resolve(input logic [31:0] pc, input logic [1:0] h, input logic t);
      logic [1:0] c;
      upd_valid = 1'b1; upd_pc = pc; upd_hist = h; upd_taken = t;
      @(posedge clk);
      c = mdl[h][pc[11:2]];
      if (t && c != 2'b11) c = c + 2'b01;
      if (!t && c != 2'b00) c = c - 2'b01;
      mdl[h][pc[11:2]] = c;
      mh = {t, mh[1]};
      #1;
      upd_valid = 1'b0;
   endtask

   task automatic steer(input logic [1:0] k);
      resolve(SCRATCH, mh, k[0]);
      resolve(SCRATCH, mh, k[1]);
   endtask

   task automatic look(input logic [31:0] pc, input string req, input logic exp);
      lu_pc = pc;
      #1;
      chk(req, int'(lu_taken), int'(exp));
   endtask

   task automatic t_reset();
      look(32'h0000_0000, "R1 reset prediction pc0", 1'b0);
      look(32'h0000_0404, "R1 reset prediction pc404", 1'b0);
      chk("R1 reset history", int'(lu_hist), 0);
   endtask

   task automatic t_hist();
      resolve(SCRATCH, mh, 1'b0);
      resolve(SCRATCH, mh, 1'b0);
      chk("R4 history after N,N", int'(lu_hist), 0);
      resolve(SCRATCH, mh, 1'b1);
      chk("R4 history after T", int'(lu_hist), 2);
      resolve(SCRATCH, mh, 1'b0);
      chk("R4 history older T newer N", int'(lu_hist), 1);
      resolve(SCRATCH, mh, 1'b1);
      resolve(SCRATCH, mh, 1'b1);
      chk("R4 history after T,T", int'(lu_hist), 3);
   endtask

   task automatic t_counter();
      logic [31:0] a = 32'h0000_0100;
      resolve(a, 2'd0, 1'b1);
      steer(2'd0);
      look(a, "R6 one taken step predicts taken", 1'b1);
      resolve(a, 2'd0, 1'b1);
      resolve(a, 2'd0, 1'b1);
      resolve(a, 2'd0, 1'b0);
      steer(2'd0);
      look(a, "R6 single miss from strong keeps taken", 1'b1);
      resolve(a, 2'd0, 1'b0);
      steer(2'd0);
      look(a, "R6 second miss flips to not taken", 1'b0);
      resolve(a, 2'd0, 1'b0);
      resolve(a, 2'd0, 1'b0);
      resolve(a, 2'd0, 1'b0);
      resolve(a, 2'd0, 1'b1);
      steer(2'd0);
      look(a, "R6 floor saturates, one taken stays not taken", 1'b0);
   endtask

   task automatic t_select();
      logic [31:0] d = 32'h0000_0200;
      resolve(d, 2'd2, 1'b1);
      resolve(d, 2'd2, 1'b1);
      for (int k = 0; k < 4; k++) begin
         steer(2'(k));
         chk("R3 steered history value", int'(lu_hist), k);
         look(d, "R7 only table 2 trained, R3 table by history", k == 2);
      end
   endtask

   task automatic t_idle();
      logic [31:0] d = 32'h0000_0200;
      steer(2'd2);
      upd_valid = 1'b0; upd_pc = d; upd_hist = 2'd2; upd_taken = 1'b0;
      repeat (5) @(posedge clk);
      #1;
      chk("R5 history holds while idle", int'(lu_hist), 2);
      look(d, "R5 idle inputs leave counter", 1'b1);
   endtask

   task automatic t_same();
      logic [31:0] c = 32'h0000_0300;
      logic [1:0] h;
      h = mh;
      lu_pc = c;
      upd_valid = 1'b1; upd_pc = c; upd_hist = h; upd_taken = 1'b1;
      #1;
      chk("R8 same-cycle lookup returns old value", int'(lu_taken), 0);
      @(posedge clk);
      mdl[h][c[11:2]] = 2'b10;
      mh = {1'b1, mh[1]};
      #1;
      upd_valid = 1'b0;
      steer(h);
      look(c, "R8 write lands after the edge", 1'b1);
   endtask

   task automatic t_alias();
      logic [31:0] e = 32'h0000_0500;
      resolve(e | 32'h3, 2'd1, 1'b1);
      resolve(e + 32'h1000, 2'd1, 1'b1);
      steer(2'd1);
      look(e, "R9 low and high PC bits alias", 1'b1);
      look(e + 32'h4, "R9 next index untouched", 1'b0);
   endtask

   task automatic t_learn();
      logic [31:0] f = 32'h0000_0600;
      for (int i = 0; i < 16; i++) begin
         logic outc;
         logic [1:0] h;
         outc = (i % 2) == 0;
         lu_pc = f;
         #1;
         h = lu_hist;
         chk("R2 lookup matches model", int'(lu_taken), int'(mdl[mh][f[11:2]][1]));
         if (i >= 12) chk("R2 alternating pattern learned", int'(lu_taken), int'(outc));
         resolve(f, h, outc);
      end
   endtask

   initial begin
      for (int t = 0; t < 4; t++)
         for (int i = 0; i < 1024; i++) mdl[t][i] = 2'b01;
      mh = 2'b00;
      rst = 1'b1; lu_pc = '0; upd_valid = 1'b0; upd_pc = '0; upd_hist = '0; upd_taken = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      rst = 1'b0;
      t_reset();
      t_hist();
      t_counter();
      t_select();
      t_idle();
      t_same();
      t_alias();
      t_learn();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule